// File: doc/BRIEF.md
# External interrupt conditioning controller

This block prepares the raw external interrupt sources of a chip so that a downstream platform interrupt controller can use them. There are three kinds of source: one non-maskable interrupt pin, a small group of IRQ pins, and a wide bank of GPIO interrupt lines. All of these inputs are asynchronous, so each one first passes through a two-flop synchronizer. A third registered stage then holds the previous value, and edge detection compares the two.

The GPIO bank is not passed through line by line. A fixed number of routed interrupt slots each pick one GPIO line through a select field. Every routed slot, every IRQ pin and the NMI has its own detection mode and a status bit. The block also combines two groups of error inputs into single interrupts. One group is bus errors and the other is memory ECC errors, and each group is an OR of its inputs.

Each output is gated twice. A per-source mask gates its own output, and one global mask, when set, gates every output. Software uses a flat word-addressed register port to configure the block, read status and clear sticky bits. The register port is a plain control path: a write takes effect on the clock edge where `reg_we` is high, and a read returns data combinationally for `reg_addr`. The port has no handshake and never stalls.

Top module: `ext_irq_cond`

## Requirements
- R1: A change on `nmi_i`, `irq_i` or a routed `gpio_i` line reaches the status bit and the output on the third rising clock edge after the change, and not on the second.
- R2: Routed slot i takes its source from GPIO line `sel`, held in bits [6:0] of register 0x20+i (reset value i). A `sel` value of 82 or more selects a constant high line. Changing `sel` never produces an edge by itself.
- R3: The mode code of an IRQ pin or routed slot selects its detection: 00 is low level, 01 is falling edge, 10 is rising edge and 11 is both edges. For an IRQ pin the code sits in bits [1:0] of register 0x10+k. For a routed slot it sits in bits [9:8] of its register. The reset mode is 01.
- R4: The NMI detects a falling edge when bit 1 of CTRL (0x00) is 0, and a rising edge when that bit is 1. No other NMI mode exists.
- R5: A detected edge sets a sticky status bit. Writing 1 to that bit clears it: NMI is bit 0 and IRQ k is bit 8+k of 0x01, and slot i is bit i of 0x02. If a new edge arrives in the same cycle as the clear, the edge wins.
- R6: In low-level mode the status bit shows the inverted synchronized input. A write of 1 to that bit has no effect.
- R7: The bus-error output and its status (bit 1 of 0x01) are the registered OR of all `bus_err_i` lines, and they follow the inputs one clock edge later. The ECC output and its status (bit 2 of 0x01) work the same way for `ecc_err_i`.
- R8: A per-source mask blocks only that source's output, and status still latches while the source is masked. The NMI mask is bit 2 of CTRL, an IRQ mask is bit 4 of its register, and a slot mask is bit 12 of its register.
- R9: When the global mask (CTRL bit 0) is 1, every output is low. Clearing the global mask brings back the outputs of pending unmasked sources.
- R10: After reset, every output is low, CTRL reads 0 and both status words read 0.
- R11: Configuration registers read back the values that were written to them, in the fields listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Asynchronous NMI pin |
| irq_i | input | N_IRQ (8) | Asynchronous IRQ pins |
| gpio_i | input | N_GPIO (82) | Asynchronous GPIO interrupt lines |
| bus_err_i | input | N_BUS (4) | Synchronous bus-error interrupt lines |
| ecc_err_i | input | N_ECC (4) | Synchronous RAM ECC-error interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nmi_o | output | 1 | Conditioned NMI |
| irq_o | output | N_IRQ (8) | Conditioned IRQ interrupts |
| tint_o | output | N_TINT (32) | Conditioned routed GPIO interrupts |
| bus_err_o | output | 1 | Integrated bus-error interrupt |
| ecc_err_o | output | 1 | Integrated ECC-error interrupt |

## Verification
A software clear of a sticky status bit can land on the same clock edge as a new edge on that source. The bench provokes this on an IRQ pin in both-edge mode. First a falling edge sets the status bit. Then the pin rises, and the write of 1 is timed so that it is applied on exactly the edge where the rise sets the status. The status must still read 1 after that write. A second clear with the input idle must then bring it to 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_BOTH = 2'b11
  } det_mode_e;

  localparam logic [7:0] ADDR_CTRL      = 8'h00;
  localparam logic [7:0] ADDR_STAT_A    = 8'h01;
  localparam logic [7:0] ADDR_STAT_T    = 8'h02;
  localparam logic [7:0] ADDR_IRQ_BASE  = 8'h10;
  localparam logic [7:0] ADDR_TINT_BASE = 8'h20;
endpackage

// File: rtl/irqc_sync_bank.sv
module irqc_sync_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1;

  // idle level is high; reset to it so no edge appears after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      sync_o <= '1;
      prev_o <= '1;
    end else begin
      stage1 <= async_i;
      sync_o <= stage1;
      prev_o <= sync_o;
    end
  end
endmodule

// File: rtl/irqc_det_cell.sv
module irqc_det_cell
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  det_mode_e mode_i,
  input  logic      cur_i,
  input  logic      prev_i,
  input  logic      clr_i,
  output logic      stat_o
);
  logic hit;

  always_comb begin
    unique case (mode_i)
      DET_FALL: hit = prev_i & ~cur_i;
      DET_RISE: hit = ~prev_i & cur_i;
      DET_BOTH: hit = prev_i ^ cur_i;
      default:  hit = 1'b0;
    endcase
  end

  // set beats clear; level mode tracks the inverted input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stat_o <= 1'b0;
    else if (mode_i == DET_LOW) stat_o <= ~cur_i;
    else if (hit)              stat_o <= 1'b1;
    else if (clr_i)            stat_o <= 1'b0;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != DET_LOW && stat_o && !clr_i) |=> stat_o); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != DET_LOW && !stat_o && cur_i == prev_i) |=> !stat_o); // R3
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import irqc_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int N_GPIO = 82,
  parameter int N_TINT = 32,
  parameter int N_BUS  = 4,
  parameter int N_ECC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic [N_BUS-1:0]  bus_err_i,
  input  logic [N_ECC-1:0]  ecc_err_i,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              nmi_o,
  output logic [N_IRQ-1:0]  irq_o,
  output logic [N_TINT-1:0] tint_o,
  output logic              bus_err_o,
  output logic              ecc_err_o
);
  localparam int SEL_W = $clog2(N_GPIO + 1);
  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(N_GPIO);

  // configuration
  logic              gmask_q, nmi_rise_q, nmi_mask_q;
  det_mode_e         irq_mode_q  [N_IRQ];
  logic [N_IRQ-1:0]  irq_mask_q;
  logic [SEL_W-1:0]  tint_sel_q  [N_TINT];
  det_mode_e         tint_mode_q [N_TINT];
  logic [N_TINT-1:0] tint_mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q     <= 1'b0;
      nmi_rise_q  <= 1'b0;
      nmi_mask_q  <= 1'b0;
      irq_mask_q  <= '0;
      tint_mask_q <= '0;
      for (int k = 0; k < N_IRQ; k++) irq_mode_q[k] <= DET_FALL;
      for (int i = 0; i < N_TINT; i++) begin
        tint_mode_q[i] <= DET_FALL;
        tint_sel_q[i]  <= SEL_W'(i % N_GPIO);
      end
    end else if (reg_we) begin
      if (reg_addr == ADDR_CTRL) begin
        gmask_q    <= reg_wdata[0];
        nmi_rise_q <= reg_wdata[1];
        nmi_mask_q <= reg_wdata[2];
      end
      for (int k = 0; k < N_IRQ; k++) begin
        if (reg_addr == ADDR_IRQ_BASE + 8'(k)) begin
          irq_mode_q[k] <= det_mode_e'(reg_wdata[1:0]);
          irq_mask_q[k] <= reg_wdata[4];
        end
      end
      for (int i = 0; i < N_TINT; i++) begin
        if (reg_addr == ADDR_TINT_BASE + 8'(i)) begin
          tint_sel_q[i]  <= reg_wdata[SEL_W-1:0];
          tint_mode_q[i] <= det_mode_e'(reg_wdata[9:8]);
          tint_mask_q[i] <= reg_wdata[12];
        end
      end
    end
  end

  // synchronizers
  logic              nmi_s, nmi_p;
  logic [N_IRQ-1:0]  irq_s, irq_p;
  logic [N_GPIO-1:0] gpio_s, gpio_p;

  irqc_sync_bank #(.W(1)) u_sync_nmi (
    .clk(clk), .rst_n(rst_n), .async_i(nmi_i), .sync_o(nmi_s), .prev_o(nmi_p));
  irqc_sync_bank #(.W(N_IRQ)) u_sync_irq (
    .clk(clk), .rst_n(rst_n), .async_i(irq_i), .sync_o(irq_s), .prev_o(irq_p));
  irqc_sync_bank #(.W(N_GPIO)) u_sync_gpio (
    .clk(clk), .rst_n(rst_n), .async_i(gpio_i), .sync_o(gpio_s), .prev_o(gpio_p));

  // write-one-to-clear strobes
  logic [31:0] clr_a, clr_t;
  assign clr_a = (reg_we && reg_addr == ADDR_STAT_A) ? reg_wdata : '0;
  assign clr_t = (reg_we && reg_addr == ADDR_STAT_T) ? reg_wdata : '0;

  // detection cells
  logic              nmi_st;
  logic [N_IRQ-1:0]  irq_st;
  logic [N_TINT-1:0] tint_st;

  irqc_det_cell u_det_nmi (
    .clk(clk), .rst_n(rst_n),
    .mode_i(nmi_rise_q ? DET_RISE : DET_FALL),
    .cur_i(nmi_s), .prev_i(nmi_p), .clr_i(clr_a[0]), .stat_o(nmi_st));

  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    irqc_det_cell u_det (
      .clk(clk), .rst_n(rst_n), .mode_i(irq_mode_q[k]),
      .cur_i(irq_s[k]), .prev_i(irq_p[k]), .clr_i(clr_a[8+k]), .stat_o(irq_st[k]));
  end

  for (genvar i = 0; i < N_TINT; i++) begin : g_tint
    logic in_range, cur, prev;
    assign in_range = tint_sel_q[i] < SEL_LIMIT;
    // both taps come from the same line, so reselection makes no edge
    assign cur  = in_range ? gpio_s[tint_sel_q[i]] : 1'b1;
    assign prev = in_range ? gpio_p[tint_sel_q[i]] : 1'b1;
    irqc_det_cell u_det (
      .clk(clk), .rst_n(rst_n), .mode_i(tint_mode_q[i]),
      .cur_i(cur), .prev_i(prev), .clr_i(clr_t[i]), .stat_o(tint_st[i]));
  end

  // integrated error interrupts
  logic bus_st, ecc_st;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_st <= 1'b0;
      ecc_st <= 1'b0;
    end else begin
      bus_st <= |bus_err_i;
      ecc_st <= |ecc_err_i;
    end
  end

  // output gating
  assign nmi_o     = nmi_st & ~nmi_mask_q & ~gmask_q;
  assign irq_o     = irq_st & ~irq_mask_q & {N_IRQ{~gmask_q}};
  assign tint_o    = tint_st & ~tint_mask_q & {N_TINT{~gmask_q}};
  assign bus_err_o = bus_st & ~gmask_q;
  assign ecc_err_o = ecc_st & ~gmask_q;

  // readback
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) reg_rdata[2:0] = {nmi_mask_q, nmi_rise_q, gmask_q};
    if (reg_addr == ADDR_STAT_A) begin
      reg_rdata[2:0]       = {ecc_st, bus_st, nmi_st};
      reg_rdata[8+:N_IRQ]  = irq_st;
    end
    if (reg_addr == ADDR_STAT_T) reg_rdata[N_TINT-1:0] = tint_st;
    for (int k = 0; k < N_IRQ; k++) begin
      if (reg_addr == ADDR_IRQ_BASE + 8'(k)) begin
        reg_rdata[1:0] = irq_mode_q[k];
        reg_rdata[4]   = irq_mask_q[k];
      end
    end
    for (int i = 0; i < N_TINT; i++) begin
      if (reg_addr == ADDR_TINT_BASE + 8'(i)) begin
        reg_rdata[SEL_W-1:0] = tint_sel_q[i];
        reg_rdata[9:8]       = tint_mode_q[i];
        reg_rdata[12]        = tint_mask_q[i];
      end
    end
  end

  AST_GMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |-> (!nmi_o && irq_o == '0 && tint_o == '0 && !bus_err_o && !ecc_err_o)); // R9

  AST_NMI_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_mask_q |-> !nmi_o); // R8

  AST_BUS_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_err_i && !gmask_q) |=> (bus_err_o || gmask_q)); // R7

  AST_ECC_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|ecc_err_i && !gmask_q) |=> (ecc_err_o || gmask_q)); // R7
endmodule

// File: tb/test_ext_irq_cond.sv
module test_ext_irq_cond;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              nmi_i = 1'b1;
  logic [7:0]        irq_i = '1;
  logic [81:0]       gpio_i = '1;
  logic [3:0]        bus_err_i = '0;
  logic [3:0]        ecc_err_i = '0;
  logic              reg_we = 1'b0;
  logic [7:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              nmi_o;
  logic [7:0]        irq_o;
  logic [31:0]       tint_o;
  logic              bus_err_o, ecc_err_o;

  int checks = 0;
  int failures = 0;

  ext_irq_cond i_ext_irq_cond (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .irq_i(irq_i), .gpio_i(gpio_i),
    .bus_err_i(bus_err_i), .ecc_err_i(ecc_err_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_o(nmi_o), .irq_o(irq_o), .tint_o(tint_o),
    .bus_err_o(bus_err_o), .ecc_err_o(ecc_err_o));

  always #5 clk = ~clk;

  // {slot[4:0], sel[6:0], mode[1:0], v0, v1, expected}
  localparam logic [16:0] VEC [8] = '{
    {5'd0,  7'd81, 2'b01, 1'b1, 1'b0, 1'b1},
    {5'd31, 7'd0,  2'b10, 1'b0, 1'b1, 1'b1},
    {5'd5,  7'd40, 2'b10, 1'b1, 1'b0, 1'b0},
    {5'd7,  7'd10, 2'b11, 1'b1, 1'b0, 1'b1},
    {5'd8,  7'd11, 2'b11, 1'b0, 1'b1, 1'b1},
    {5'd9,  7'd12, 2'b00, 1'b1, 1'b0, 1'b1},
    {5'd10, 7'd13, 2'b00, 1'b0, 1'b1, 1'b0},
    {5'd12, 7'd50, 2'b01, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R10 reset state
    check("R10 outputs", {nmi_o, irq_o, tint_o[0], bus_err_o, ecc_err_o}, '0);
    check("R10 tint_o", tint_o, '0);
    rd(8'h00, d); check("R10 ctrl", d, 0);
    rd(8'h01, d); check("R10 stat_a", d, 0);
    rd(8'h02, d); check("R10 stat_t", d, 0);

    // vector walk over routed slots: R2 R3
    for (int v = 0; v < 8; v++) begin
      logic [4:0] slot; logic [6:0] sel; logic [1:0] mode; logic v0, v1, ex;
      {slot, sel, mode, v0, v1, ex} = VEC[v];
      wr(8'h20 + 8'(slot), {22'd0, mode, 1'b0, sel});
      gpio_i[sel] = v0;
      step(4);
      wr(8'h02, 32'd1 << slot);
      gpio_i[sel] = v1;
      step(4);
      check($sformatf("R3 vec%0d tint_o", v), 32'(tint_o[slot]), 32'(ex));
      rd(8'h02, d);
      check($sformatf("R2 vec%0d status", v), 32'(d[slot]), 32'(ex));
    end
    rd(8'h25, d); check("R11 slot5 cfg", d, 32'h228);

    // R1 latency and default falling NMI
    nmi_i = 1'b0;
    step(2); check("R1 nmi before third edge", 32'(nmi_o), 0);
    step(1); check("R1 nmi after third edge", 32'(nmi_o), 1);
    wr(8'h01, 32'h1); check("R5 nmi cleared", 32'(nmi_o), 0);

    // R4 rising NMI, falling ignored
    wr(8'h00, 32'h2);
    nmi_i = 1'b1; step(4); check("R4 nmi rising", 32'(nmi_o), 1);
    wr(8'h01, 32'h1);
    nmi_i = 1'b0; step(4); check("R4 nmi falling ignored", 32'(nmi_o), 0);

    // R8 mask gates output, status still latches
    wr(8'h00, 32'h4);
    nmi_i = 1'b1; step(2); nmi_i = 1'b0; step(4);
    check("R8 masked nmi_o", 32'(nmi_o), 0);
    rd(8'h01, d); check("R8 status latched", 32'(d[0]), 1);
    wr(8'h00, 32'h0); check("R8 unmasked nmi_o", 32'(nmi_o), 1);
    wr(8'h01, 32'h1);

    // R7 error folding
    bus_err_i[2] = 1'b1; step(1);
    check("R7 bus_err_o", 32'(bus_err_o), 1);
    rd(8'h01, d); check("R7 bus status", 32'(d[1]), 1);
    bus_err_i[2] = 1'b0; ecc_err_i[3] = 1'b1; step(1);
    check("R7 bus drop", 32'(bus_err_o), 0);
    check("R7 ecc_err_o", 32'(ecc_err_o), 1);
    ecc_err_i[3] = 1'b0; step(1);
    check("R7 ecc drop", 32'(ecc_err_o), 0);

    // R9 global mask
    irq_i[2] = 1'b0; bus_err_i[0] = 1'b1; step(4);
    check("R9 irq2 pending", 32'(irq_o[2]), 1);
    wr(8'h00, 32'h1);
    check("R9 all blocked", {23'd0, nmi_o, irq_o, bus_err_o, ecc_err_o}, 0);
    check("R9 tint blocked", tint_o, 0);
    rd(8'h01, d); check("R9 status kept", 32'(d[10]), 1);
    wr(8'h00, 32'h0);
    check("R9 restored", {30'd0, irq_o[2], bus_err_o}, 32'h3);
    bus_err_i[0] = 1'b0; irq_i[2] = 1'b1;
    wr(8'h01, 32'h400);

    // R6 level mode not clearable
    wr(8'h13, 32'h0);
    rd(8'h13, d); check("R11 irq3 cfg", d, 0);
    irq_i[3] = 1'b0; step(4);
    check("R6 level active", 32'(irq_o[3]), 1);
    wr(8'h01, 32'h800); step(1);
    check("R6 clear ignored", 32'(irq_o[3]), 1);
    irq_i[3] = 1'b1; step(4);
    check("R6 level released", 32'(irq_o[3]), 0);

    // R5 clear and edge on the same edge: edge wins
    wr(8'h11, 32'h3);
    irq_i[1] = 1'b0; step(4);
    check("R5 both-edge fall", 32'(irq_o[1]), 1);
    irq_i[1] = 1'b1;
    step(2);
    reg_we = 1'b1; reg_addr = 8'h01; reg_wdata = 32'h200;
    step(1);
    reg_we = 1'b0;
    check("R5 set beats clear", 32'(irq_o[1]), 1);
    wr(8'h01, 32'h200);
    check("R5 plain clear", 32'(irq_o[1]), 0);

    // R2 reselection makes no edge; out-of-range sel is idle high
    gpio_i[60] = 1'b0; step(4);
    wr(8'h02, 32'h8);
    wr(8'h23, 32'h13C); step(4);
    check("R2 reselect no edge", 32'(tint_o[3]), 0);
    gpio_i[60] = 1'b1; step(2); gpio_i[60] = 1'b0; step(4);
    check("R2 rerouted line", 32'(tint_o[3]), 1);
    wr(8'h23, 32'h064); step(4);
    check("R2 out-of-range idle", 32'(tint_o[3]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule